// File: doc/BRIEF.md
# Delay-Slot Branch Resolution Unit

This unit decides, for a single-issue core with one architectural delay slot, whether a control-transfer instruction redirects fetch and whether the instruction in its delay slot must be thrown away. Each cycle the decoder may present one control-transfer instruction. The instruction arrives as a kind code together with its register operands, the target address (already computed elsewhere) and its own PC. The unit evaluates the condition and records the outcome in a small set of registers. The outcome reaches the outputs one cycle later, which is the cycle in which the delay-slot instruction completes.

Conditional kinds test the sign of one operand, or compare two operands byte lane by byte lane. The "likely" forms cancel the delay-slot instruction when their condition fails. The two unconditional kinds always redirect, and the linking form also writes the return address, its own PC plus eight, into register 31. A stall input freezes the recorded outcome. A synchronous reset clears it.

Top module: `dslot_branch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `redirect`, `annul` and `link_we` go low at that edge, and `redirect_pc` and `link_data` go to zero.
- R2: Kind 1 (positive test) and kind 3 (its likely form) are taken exactly when `opa`, read as a signed 32-bit value, is greater than zero.
- R3: Kind 2 (non-positive test) and kind 4 (its likely form) are taken exactly when `opa`, read as signed, is zero or negative.
- R4: A control-transfer instruction accepted at an edge (`valid` high, `stall` low, `annul` low) raises `redirect` after that edge for exactly one cycle when taken, with `redirect_pc` equal to the `target` it carried. `redirect_pc` is zero whenever `redirect` is low.
- R5: A likely kind (3 or 4) that is not taken raises `annul` for one cycle and leaves `redirect` low. A likely kind that is taken behaves like its plain form.
- R6: Kinds 1, 2, 5, 6 and 7 never raise `annul`, taken or not.
- R7: Kind 5 is taken when at least one of the byte lanes `opa[8k+7:8k]` equals `opb[8k+7:8k]`, for k = 0..3. With no lane equal, it is not taken.
- R8: Kind 6 (jump) and kind 7 (jump-and-link) are always taken. Kind 7 also raises `link_we` for one cycle, with `link_data` = `pc` + 8 and `link_addr` = 31. Every other kind keeps `link_we` low.
- R9: While `stall` is high (and `rst` low), `redirect`, `redirect_pc`, `annul`, `link_we` and `link_data` hold their values, and any instruction presented is ignored.
- R10: An instruction presented in a cycle where `annul` is high is the annulled delay-slot instruction. It is discarded, and all outputs are low or zero after the next edge.
- R11: With `valid` low, or with kind 0, an unstalled edge leaves all outputs low or zero.
- R12: `redirect` and `annul` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freezes the recorded outcome and blocks acceptance |
| valid | input | 1 | A control-transfer instruction is presented |
| br_kind | input | 3 | 0 none, 1 positive, 2 non-positive, 3 positive likely, 4 non-positive likely, 5 lane match, 6 jump, 7 jump-and-link |
| opa | input | 32 | First register operand |
| opb | input | 32 | Second register operand (lane match only) |
| target | input | 32 | Precomputed branch or jump destination |
| pc | input | 32 | Address of the control-transfer instruction |
| redirect | output | 1 | Fetch must continue at `redirect_pc` |
| redirect_pc | output | 32 | Redirect destination, zero when not redirecting |
| annul | output | 1 | Cancel the delay-slot instruction now completing |
| link_we | output | 1 | Write the return address to the link register |
| link_addr | output | 5 | Link register index, fixed at 31 |
| link_data | output | 32 | Return address, `pc` + 8 |

## Verification
The bench builds the unit with its default parameters: 32-bit operands and addresses, 8-bit lanes and a link offset of 8. At these values all seven kinds can be swept against a grid of operands that includes 0, 1, -1, 0x7FFFFFFF, 0x80000000 and their neighbours. Because there are only four lanes, every single-lane match can be built, along with the no-match and all-match pairs. Separate sequences cover the stall freeze, a branch presented in an annulled slot and a reset in the middle of a redirect.

// File: rtl/dslot_pkg.sv
package dslot_pkg;

    typedef enum logic [2:0] {
        BK_NONE     = 3'd0,
        BK_GTZ      = 3'd1,
        BK_LEZ      = 3'd2,
        BK_GTZ_LK   = 3'd3,
        BK_LEZ_LK   = 3'd4,
        BK_LANE     = 3'd5,
        BK_JUMP     = 3'd6,
        BK_JLINK    = 3'd7
    } br_kind_e;

    localparam int KIND_W = 3;

endpackage

// File: rtl/dslot_lane_match.sv
module dslot_lane_match #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              any_eq
);
    localparam int NUM_LANES = DATA_W / LANE_W;

    logic [NUM_LANES-1:0] lane_eq;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        assign lane_eq[k] = (a[k*LANE_W +: LANE_W] == b[k*LANE_W +: LANE_W]);
    end

    assign any_eq = |lane_eq;

endmodule

// File: rtl/dslot_cond_eval.sv
module dslot_cond_eval
    import dslot_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  br_kind_e          kind,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              is_xfer,
    output logic              taken,
    output logic              likely,
    output logic              links
);
    logic is_zero;
    logic is_neg;
    logic pos;
    logic lane_hit;

    assign is_zero = (opa == '0);
    assign is_neg  = opa[DATA_W-1];
    assign pos     = !is_neg && !is_zero;

    dslot_lane_match #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_lane (
        .a      (opa),
        .b      (opb),
        .any_eq (lane_hit)
    );

    always_comb begin
        is_xfer = 1'b1;
        taken   = 1'b0;
        likely  = 1'b0;
        links   = 1'b0;
        unique case (kind)
            BK_NONE:   is_xfer = 1'b0;
            BK_GTZ:    taken   = pos;
            BK_LEZ:    taken   = !pos;
            BK_GTZ_LK: begin taken = pos;  likely = 1'b1; end
            BK_LEZ_LK: begin taken = !pos; likely = 1'b1; end
            BK_LANE:   taken   = lane_hit;
            BK_JUMP:   taken   = 1'b1;
            BK_JLINK:  begin taken = 1'b1; links = 1'b1; end
            default:   is_xfer = 1'b0;
        endcase
    end

endmodule

// File: rtl/dslot_branch_unit.sv
module dslot_branch_unit
    import dslot_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 32,
    parameter int LANE_W   = 8,
    parameter int REG_AW   = 5,
    parameter int LINK_REG = 31,
    parameter int LINK_OFS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              valid,
    input  logic [2:0]        br_kind,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [ADDR_W-1:0] target,
    input  logic [ADDR_W-1:0] pc,
    output logic              redirect,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic              annul,
    output logic              link_we,
    output logic [REG_AW-1:0] link_addr,
    output logic [ADDR_W-1:0] link_data
);
    localparam logic [ADDR_W-1:0] LINK_STEP = ADDR_W'(LINK_OFS);
    localparam logic [REG_AW-1:0] LINK_IDX  = REG_AW'(LINK_REG);

    typedef struct packed {
        logic              redirect;
        logic              annul;
        logic              link_we;
        logic [ADDR_W-1:0] redir_pc;
        logic [ADDR_W-1:0] link_data;
    } resolve_t;

    resolve_t st_d, st_q;
    br_kind_e kind;
    logic     is_xfer, taken, likely, links;
    logic     accept;

    assign kind = br_kind_e'(br_kind);

    dslot_cond_eval #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_cond (
        .kind    (kind),
        .opa     (opa),
        .opb     (opb),
        .is_xfer (is_xfer),
        .taken   (taken),
        .likely  (likely),
        .links   (links)
    );

    // an instruction in an annulled slot is never accepted
    assign accept = valid && !stall && !st_q.annul && is_xfer;

    always_comb begin
        st_d = st_q;
        if (!stall) begin
            st_d = '0;
            if (accept) begin
                st_d.redirect  = taken;
                st_d.annul     = likely && !taken;
                st_d.redir_pc  = taken ? target : '0;
                st_d.link_we   = links;
                st_d.link_data = links ? (pc + LINK_STEP) : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign redirect    = st_q.redirect;
    assign redirect_pc = st_q.redir_pc;
    assign annul       = st_q.annul;
    assign link_we     = st_q.link_we;
    assign link_addr   = LINK_IDX;
    assign link_data   = st_q.link_data;

    AST_NO_REDIR_WITH_ANNUL: assert property (@(posedge clk) disable iff (rst)
        !(redirect && annul)); // R12

    AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(redirect) && $stable(annul) && $stable(link_we)
                  && $stable(redirect_pc) && $stable(link_data)); // R9

    AST_SLOT_DISCARDED: assert property (@(posedge clk) disable iff (rst)
        (annul && !stall) |=> !redirect && !annul && !link_we); // R10

    AST_LINK_ADDR: assert property (@(posedge clk) disable iff (rst)
        (valid && !stall && !annul && br_kind == 3'd7)
        |=> link_we && redirect && link_data == $past(pc) + LINK_STEP); // R8

    AST_JUMP_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (valid && !stall && !annul && br_kind == 3'd6)
        |=> redirect && redirect_pc == $past(target)); // R4

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!valid && !stall) |=> !redirect && !annul && !link_we); // R11

    AST_PLAIN_NO_ANNUL: assert property (@(posedge clk) disable iff (rst)
        (valid && !stall && !annul && br_kind != 3'd3 && br_kind != 3'd4)
        |=> !annul); // R6

endmodule

// File: tb/sim_dslot_branch_unit.sv
`timescale 1ns/1ps
module sim_dslot_branch_unit;
    logic        clk = 1'b0;
    logic        rst, stall, valid;
    logic [2:0]  br_kind;
    logic [31:0] opa, opb, target, pc;
    logic        redirect, annul, link_we;
    logic [31:0] redirect_pc, link_data;
    logic [4:0]  link_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dslot_branch_unit u0 (
        .clk(clk), .rst(rst), .stall(stall), .valid(valid), .br_kind(br_kind),
        .opa(opa), .opb(opb), .target(target), .pc(pc),
        .redirect(redirect), .redirect_pc(redirect_pc), .annul(annul),
        .link_we(link_we), .link_addr(link_addr), .link_data(link_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " redirect"}, 32'(redirect), 32'd0);
        chk({tag, " redirect_pc"}, redirect_pc, 32'd0);
        chk({tag, " annul"}, 32'(annul), 32'd0);
        chk({tag, " link_we"}, 32'(link_we), 32'd0);
        chk({tag, " link_data"}, link_data, 32'd0);
    endtask

    function automatic bit model_taken(input int k, input logic [31:0] a, input logic [31:0] b);
        bit hit = 1'b0;
        case (k)
            1, 3: return $signed(a) > 0;
            2, 4: return $signed(a) <= 0;
            5: begin
                for (int l = 0; l < 4; l++)
                    if (a[8*l +: 8] == b[8*l +: 8]) hit = 1'b1;
                return hit;
            end
            6, 7: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic issue(input int k, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] tgt, input logic [31:0] pcv);
        bit t, lk;
        t  = model_taken(k, a, b);
        lk = (k == 3 || k == 4);
        @(negedge clk);
        valid = 1'b1; br_kind = 3'(k); opa = a; opb = b; target = tgt; pc = pcv;
        @(negedge clk);
        valid = 1'b0; br_kind = 3'd0;
        // R2 R3 R7 R8: taken decision; R4 redirect target
        chk($sformatf("R4 kind%0d a=%h b=%h redirect", k, a, b), 32'(redirect), 32'(t));
        chk($sformatf("R4 kind%0d redirect_pc", k), redirect_pc, t ? tgt : 32'd0);
        // R5 R6: annul only for likely not taken
        chk($sformatf("R5_R6 kind%0d a=%h annul", k, a), 32'(annul), 32'(lk && !t));
        chk($sformatf("R8 kind%0d link_we", k), 32'(link_we), 32'(k == 7));
        chk($sformatf("R8 kind%0d link_data", k), link_data, (k == 7) ? pcv + 32'd8 : 32'd0);
        chk("R8 link_addr", 32'(link_addr), 32'd31);
        @(negedge clk);
        chk_idle("R4 pulse ends");
    endtask

    initial begin
        logic [31:0] ops [7];
        logic [31:0] base;
        logic [31:0] bb;
        ops[0] = 32'h0000_0000; ops[1] = 32'h0000_0001; ops[2] = 32'hFFFF_FFFF;
        ops[3] = 32'h7FFF_FFFF; ops[4] = 32'h8000_0000; ops[5] = 32'h0000_0002;
        ops[6] = 32'hFFFF_FFFE;
        rst = 1'b1; stall = 1'b0; valid = 1'b0; br_kind = 3'd0;
        opa = '0; opb = '0; target = '0; pc = '0;
        repeat (3) @(negedge clk);
        chk_idle("R1 reset");
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R11 idle after reset");

        // sign-test kinds, plain and likely, plus jumps
        for (int k = 1; k <= 7; k++)
            for (int i = 0; i < 7; i++)
                issue(k, ops[i], ops[(i + 3) % 7], 32'h1000_0000 + 32'(k * 64 + i * 4),
                      32'h0040_0000 + 32'(i * 8));

        // R7: lane match over operand grid and crafted single-lane hits
        for (int i = 0; i < 7; i++)
            for (int j = 0; j < 7; j++)
                issue(5, ops[i], ops[j], 32'h2000_0000 + 32'(i * 32 + j * 4), 32'h100);
        base = 32'h1122_3344;
        for (int l = 0; l < 4; l++) begin
            bb = ~base;
            bb[8*l +: 8] = base[8*l +: 8];
            issue(5, base, bb, 32'h3000_0000 + 32'(l * 4), 32'h200);
        end
        issue(5, base, ~base, 32'h3000_0040, 32'h200);
        issue(5, base, base, 32'h3000_0044, 32'h200);

        // R11: kind 0 with valid high does nothing
        @(negedge clk);
        valid = 1'b1; br_kind = 3'd0; target = 32'hDEAD_0000;
        @(negedge clk);
        valid = 1'b0;
        chk_idle("R11 kind none");

        // R9: stall freezes outcome and ignores a new instruction
        @(negedge clk);
        valid = 1'b1; br_kind = 3'd7; target = 32'h4000_0000; pc = 32'h0000_1000;
        @(negedge clk);
        stall = 1'b1; valid = 1'b1; br_kind = 3'd6; target = 32'h5000_0000;
        chk("R8 link before stall", link_data, 32'h0000_1008);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R9 stall redirect", 32'(redirect), 32'd1);
            chk("R9 stall redirect_pc", redirect_pc, 32'h4000_0000);
            chk("R9 stall link_we", 32'(link_we), 32'd1);
            chk("R9 stall link_data", link_data, 32'h0000_1008);
        end
        stall = 1'b0; valid = 1'b0; br_kind = 3'd0;
        @(negedge clk);
        chk_idle("R9 after stall");

        // R9: stall holds an annul too
        @(negedge clk);
        valid = 1'b1; br_kind = 3'd4; opa = 32'h0000_0005; target = 32'h6000_0000;
        @(negedge clk);
        valid = 1'b0; stall = 1'b1;
        chk("R5 likely not taken annul", 32'(annul), 32'd1);
        @(negedge clk);
        chk("R9 stall annul", 32'(annul), 32'd1);
        chk("R12 no redirect with annul", 32'(redirect), 32'd0);
        stall = 1'b0;
        @(negedge clk);
        chk_idle("R9 annul released");

        // R10: instruction in annulled slot is discarded
        @(negedge clk);
        valid = 1'b1; br_kind = 3'd3; opa = 32'h8000_0000; target = 32'h7000_0000;
        @(negedge clk);
        chk("R10 annul set", 32'(annul), 32'd1);
        valid = 1'b1; br_kind = 3'd7; target = 32'h7100_0000; pc = 32'h44;
        @(negedge clk);
        valid = 1'b0; br_kind = 3'd0;
        chk_idle("R10 slot discarded");

        // R1: reset in the middle of a redirect
        @(negedge clk);
        valid = 1'b1; br_kind = 3'd6; target = 32'h7200_0000;
        @(negedge clk);
        valid = 1'b0; rst = 1'b1;
        chk("R4 before reset", 32'(redirect), 32'd1);
        @(negedge clk);
        rst = 1'b0;
        chk_idle("R1 mid-run reset");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule